// File: doc/BRIEF.md
# SPI Event Interrupt and Soft-Reset Unit

This unit sits beside a serial-peripheral core and turns six event lines from that core into one level-sensitive interrupt for a processor. Each event line is watched for a low-to-high transition. A transition sets a sticky bit in a 32-bit pending register. Each pending bit is qualified by its own mask bit. A single master enable bit then gates the OR of the qualified bits to form `irq_o`. Software reads the pending register and writes the same value back to acknowledge exactly the events it saw. Events that arrive in between stay pending.

The same register port holds a guarded restart register. Writing the key value `0x0A` to it starts a one-cycle restart pulse to the attached core. The same write empties the pending register, the mask register and the master enable. Any other value written there is ignored.

The restart pulse comes from a two-state sequencer.
- States: `SEQ_IDLE` (pulse low) and `SEQ_FIRE` (pulse high).
- Transitions:
  - `SEQ_IDLE -> SEQ_FIRE` on a key write.
  - `SEQ_FIRE -> SEQ_IDLE` when no key write is present.
  - `SEQ_FIRE -> SEQ_FIRE` when a further key write arrives during the pulse.
  - `SEQ_IDLE -> SEQ_IDLE` otherwise.

Reads are combinational from the addressed register. Writes take effect at the rising clock edge.

Top module: `irq_rst_unit`

## Requirements
- R1: After `rst_n` is released, every register reads zero, and `irq_o` and `core_rst_o` are low.
- R2: A 0-to-1 change on `evt_i[k]` sets pending bit k at the edge that first samples the line high. The bit stays set after the line falls, until it is cleared.
- R3: A write to offset 0x20 clears each pending bit whose `bus_wdata` bit is 1 and leaves the others unchanged. The pending bits are:
  - bit 0: master-side fault
  - bit 1: selected-while-off fault
  - bit 2: transmit queue empty
  - bit 3: transmit starved
  - bit 4: receive queue full
  - bit 5: receive overflow
  - bits 31:6 read zero.
- R4: The master enable is bit 31 of offset 0x1C, and the other bits read zero. `irq_o` is high exactly when the master enable is set and some pending bit has its mask bit set.
- R5: Offset 0x28 holds the mask in bits 5:0, which are read/write. Bits 31:6 read zero.
- R6: A write of 0x0000000A to offset 0x40 drives `core_rst_o` high during the one clock cycle that follows the write edge.
- R7: A write of any other value to offset 0x40 produces no pulse and changes no register.
- R8: A key write clears the pending, mask and master enable registers at its edge, overriding any event or write in that cycle.
- R9: When an event rise and a clear write hit the same pending bit in one cycle, the bit ends up set.
- R10: Reads of offset 0x40 and of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte offset for the read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| evt_i | input | 6 | Event lines from the serial core |
| irq_o | output | 1 | Level interrupt request |
| core_rst_o | output | 1 | One-cycle restart pulse to the core |

## Verification
Read data follows `bus_addr` in the same cycle, before any edge. The bench therefore checks `bus_rdata` 1 ns after it drives the address at the falling edge.

Pending bits, mask, master enable and `irq_o` reflect a stimulus right after the rising edge that samples it. `core_rst_o` is high for the cycle that begins at the key-write edge. Both are checked 1 ns after that rising edge.

A bench-side model advances once per edge using only the requirements, so every comparison lands on the cycle in which the result is due.

// File: rtl/irq_rst_pkg.sv
package irq_rst_pkg;

    // Register offsets decoded by software; kept at fixed positions.
    localparam logic [7:0] OFS_MASTER = 8'h1C;
    localparam logic [7:0] OFS_PEND   = 8'h20;
    localparam logic [7:0] OFS_MASK   = 8'h28;
    localparam logic [7:0] OFS_RESTART = 8'h40;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_FIRE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [NUM_SRC-1:0] rise_o
);

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            logic evt_d;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    evt_d <= 1'b0;
                end else begin
                    evt_d <= evt_i[g];
                end
            end

            assign rise_o[g] = evt_i[g] & ~evt_d;
        end
    endgenerate

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic               wipe_i,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    input  logic               master_we_i,
    input  logic               master_wdata_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               master_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o   <= '0;
            mask_o   <= '0;
            master_o <= 1'b0;
        end else if (wipe_i) begin
            pend_o   <= '0;
            mask_o   <= '0;
            master_o <= 1'b0;
        end else begin
            // an arriving rise outranks a clear of the same bit
            pend_o <= (pend_o & ~clr_i) | rise_i;
            if (mask_we_i) begin
                mask_o <= mask_wdata_i;
            end
            if (master_we_i) begin
                master_o <= master_wdata_i;
            end
        end
    end

endmodule

// File: rtl/irq_rst_seq.sv
module irq_rst_seq
    import irq_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic core_rst_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (fire_i) state_d = SEQ_FIRE;
            SEQ_FIRE: state_d = fire_i ? SEQ_FIRE : SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SEQ_FIRE: core_rst_o = 1'b1;
            default:  core_rst_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_rst_unit.sv
module irq_rst_unit
    import irq_rst_pkg::*;
#(
    parameter int                NUM_SRC = 6,
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_KEY = 'h0A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic               irq_o,
    output logic               core_rst_o
);

    localparam int TOP_BIT = DATA_W - 1;

    logic [NUM_SRC-1:0] rise_w;
    logic [NUM_SRC-1:0] clr_w;
    logic [NUM_SRC-1:0] status_w;
    logic [NUM_SRC-1:0] enable_w;
    logic               gie_w;
    logic               wr_master;
    logic               wr_pend;
    logic               wr_mask;
    logic               key_hit;

    always_comb begin
        wr_master = bus_we && (bus_addr == ADDR_W'(OFS_MASTER));
        wr_pend   = bus_we && (bus_addr == ADDR_W'(OFS_PEND));
        wr_mask   = bus_we && (bus_addr == ADDR_W'(OFS_MASK));
        key_hit   = bus_we && (bus_addr == ADDR_W'(OFS_RESTART))
                    && (bus_wdata == RST_KEY);
        clr_w     = wr_pend ? bus_wdata[NUM_SRC-1:0] : '0;
    end

    irq_edge_cap #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .rise_o (rise_w)
    );

    irq_status_reg #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .rise_i         (rise_w),
        .clr_i          (clr_w),
        .wipe_i         (key_hit),
        .mask_we_i      (wr_mask),
        .mask_wdata_i   (bus_wdata[NUM_SRC-1:0]),
        .master_we_i    (wr_master),
        .master_wdata_i (bus_wdata[TOP_BIT]),
        .pend_o         (status_w),
        .mask_o         (enable_w),
        .master_o       (gie_w)
    );

    irq_rst_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (key_hit),
        .core_rst_o (core_rst_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_MASTER): bus_rdata[TOP_BIT] = gie_w;
            ADDR_W'(OFS_PEND):   bus_rdata[NUM_SRC-1:0] = status_w;
            ADDR_W'(OFS_MASK):   bus_rdata[NUM_SRC-1:0] = enable_w;
            default:             bus_rdata = '0;
        endcase
    end

    assign irq_o = gie_w & (|(status_w & enable_w));

endmodule

// File: rtl/irq_rst_unit_chk.sv
module irq_rst_unit_chk
    import irq_rst_pkg::*;
#(
    parameter int                NUM_SRC = 6,
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_KEY = 'h0A
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               irq_o,
    input logic               core_rst_o,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic               gie_q
);

    logic [NUM_SRC-1:0] evt_seen;
    logic [NUM_SRC-1:0] rise_c;
    logic [NUM_SRC-1:0] keep_c;
    logic               key_c;
    logic               badkey_c;
    logic               gie_off_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_seen <= '0;
        else        evt_seen <= evt_i;
    end

    always_comb begin
        rise_c    = evt_i & ~evt_seen;
        key_c     = bus_we && (bus_addr == ADDR_W'(OFS_RESTART)) && (bus_wdata == RST_KEY);
        badkey_c  = bus_we && (bus_addr == ADDR_W'(OFS_RESTART)) && (bus_wdata != RST_KEY);
        gie_off_c = bus_we && (bus_addr == ADDR_W'(OFS_MASTER)) && !bus_wdata[DATA_W-1];
        keep_c    = status_q & ~((bus_we && (bus_addr == ADDR_W'(OFS_PEND)))
                                 ? bus_wdata[NUM_SRC-1:0] : '0);
    end

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_c |=> ((status_q & $past(keep_c)) == $past(keep_c)));

    // R9
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rise_c) && !key_c) |=> ((status_q & $past(rise_c)) == $past(rise_c)));

    // R4
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_off_c && !key_c) |=> !irq_o);

    // R6
    key_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_c |=> core_rst_o);

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_o && !key_c) |=> !core_rst_o);

    // R7
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        badkey_c |=> !core_rst_o);

    // R8
    key_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_c |=> (status_q == '0 && enable_q == '0 && !gie_q && !irq_o));

endmodule

bind irq_rst_unit irq_rst_unit_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RST_KEY (RST_KEY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .evt_i      (evt_i),
    .irq_o      (irq_o),
    .core_rst_o (core_rst_o),
    .status_q   (status_w),
    .enable_q   (enable_w),
    .gie_q      (gie_w)
);

// File: tb/irq_rst_unit_tb.sv
module irq_rst_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_i = 6'h0;
    logic        irq_o;
    logic        core_rst_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // requirement-level model
    logic [5:0] m_st = '0;
    logic [5:0] m_en = '0;
    logic       m_g = 1'b0;
    logic [5:0] m_prev = '0;
    logic       m_pulse = 1'b0;

    always #5 clk = ~clk;

    irq_rst_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt_i      (evt_i),
        .irq_o      (irq_o),
        .core_rst_o (core_rst_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h1C:   return {m_g, 31'h0};
            8'h20:   return {26'h0, m_st};
            8'h28:   return {26'h0, m_en};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        case (a)
            8'h1C:   return "R4";
            8'h20:   return "R3";
            8'h28:   return "R5";
            default: return "R10";
        endcase
    endfunction

    // one clock: drive at falling edge, check read, step model, check outputs
    task automatic cyc(input logic [5:0] ev, input bit we, input logic [7:0] a,
                       input logic [31:0] d);
        logic [5:0] rise;
        logic [5:0] clr;
        bit key;
        @(negedge clk);
        evt_i = ev; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        if (!we) chk(bus_rdata == exp_read(a), read_tag(a), "read", bus_rdata, exp_read(a));
        rise = ev & ~m_prev;
        key  = we && a == 8'h40 && d == 32'h0A;
        if (key) begin
            m_st = '0; m_en = '0; m_g = 1'b0;
        end else begin
            clr  = (we && a == 8'h20) ? d[5:0] : 6'h0;
            m_st = (m_st & ~clr) | rise;
            if (we && a == 8'h28) m_en = d[5:0];
            if (we && a == 8'h1C) m_g = d[31];
        end
        m_prev  = ev;
        m_pulse = key;
        @(posedge clk);
        #1;
        chk(core_rst_o == m_pulse, "R6", "core_rst_o", {31'h0, core_rst_o}, {31'h0, m_pulse});
        chk(irq_o == (m_g && |(m_st & m_en)), "R4", "irq_o", {31'h0, irq_o},
            {31'h0, (m_g && |(m_st & m_en))});
    endtask

    // combinational read between edges, write strobe held low
    task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string req);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(bus_rdata == exp, req, "peek", bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] cur;
        logic [7:0] a;
        logic [31:0] d;
        bit we;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(irq_o == 1'b0, "R1", "irq_o", {31'h0, irq_o}, 32'h0);
        chk(core_rst_o == 1'b0, "R1", "core_rst_o", {31'h0, core_rst_o}, 32'h0);
        peek(8'h1C, 32'h0, "R1");
        peek(8'h20, 32'h0, "R1");
        peek(8'h28, 32'h0, "R1");

        // R5 mask write, upper bits dropped
        cyc(6'h00, 1'b1, 8'h28, 32'hFFFF_FFFF);
        peek(8'h28, 32'h0000_003F, "R5");
        // R4 master enable alone raises nothing
        cyc(6'h00, 1'b1, 8'h1C, 32'hFFFF_FFFF);
        peek(8'h1C, 32'h8000_0000, "R4");
        chk(irq_o == 1'b0, "R4", "irq idle", {31'h0, irq_o}, 32'h0);
        // R2 rise of transmit-empty line, then it falls
        cyc(6'h04, 1'b0, 8'h20, 32'h0);
        chk(irq_o == 1'b1, "R2", "irq after rise", {31'h0, irq_o}, 32'h1);
        cyc(6'h00, 1'b0, 8'h20, 32'h0);
        peek(8'h20, 32'h0000_0004, "R2");
        // R9 rise on bit 0 with clear of bits 0 and 2 in the same cycle
        cyc(6'h01, 1'b1, 8'h20, 32'h0000_0005);
        peek(8'h20, 32'h0000_0001, "R9");
        // R3 clear leaves unselected bits
        cyc(6'h13, 1'b0, 8'h20, 32'h0);
        cyc(6'h13, 1'b1, 8'h20, 32'h0000_0002);
        peek(8'h20, 32'h0000_0011, "R3");
        // R4 master off drops irq
        cyc(6'h13, 1'b1, 8'h1C, 32'h0);
        chk(irq_o == 1'b0, "R4", "irq master off", {31'h0, irq_o}, 32'h0);
        cyc(6'h13, 1'b1, 8'h1C, 32'h8000_0000);
        // R7 wrong key
        cyc(6'h13, 1'b1, 8'h40, 32'h0000_000B);
        chk(core_rst_o == 1'b0, "R7", "no pulse", {31'h0, core_rst_o}, 32'h0);
        peek(8'h20, 32'h0000_0011, "R7");
        peek(8'h28, 32'h0000_003F, "R7");
        peek(8'h1C, 32'h8000_0000, "R7");
        // R10 restart and unmapped offsets read zero
        peek(8'h40, 32'h0, "R10");
        peek(8'h44, 32'h0, "R10");
        // R6 / R8 key write, with a simultaneous rise on bit 5
        cyc(6'h33, 1'b1, 8'h40, 32'h0000_000A);
        chk(core_rst_o == 1'b1, "R6", "pulse", {31'h0, core_rst_o}, 32'h1);
        peek(8'h20, 32'h0, "R8");
        peek(8'h28, 32'h0, "R8");
        peek(8'h1C, 32'h0, "R8");
        cyc(6'h33, 1'b0, 8'h20, 32'h0);
        chk(core_rst_o == 1'b0, "R6", "pulse end", {31'h0, core_rst_o}, 32'h0);

        // random phase
        cur = 6'h33;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) cur = cur ^ 6'($urandom);
            we = ($urandom_range(0, 1) == 1);
            case ($urandom_range(0, 4))
                0: a = 8'h1C;
                1: a = 8'h20;
                2: a = 8'h28;
                3: a = 8'h40;
                default: a = 8'h44;
            endcase
            d = $urandom;
            if (a == 8'h40 && $urandom_range(0, 3) == 0) d = 32'h0000_000A;
            cyc(cur, we, a, d);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule